// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Transceiver (Master or Slave)

This block moves one byte at a time over a three-wire synchronous serial link: a serial clock, a master-out data line and a master-in data line, plus an active-low select input used in slave mode. Software uses three registers: control, status and data. In master mode, writing the data register starts a full-duplex exchange. The block generates exactly eight serial clock pulses at a rate divided down from the system clock, then parks the clock low and raises a completion flag. When enabled, that flag drives an interrupt line. In slave mode, the block follows the external clock while its select input is held low. The external lines are first passed through synchronizers.

The shift register is shared between the transmit and receive directions. When the byte finishes, the data register holds what the far side sent, and the far side holds what this side sent. The serial clock idles low. Data changes on the falling edge and is captured on the rising edge. The first bit is presented on the data line before the first rising edge.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, `irq` is 0, and `sck_drive`, `mosi_drive` and `miso_drive` are 0.
- R2: In master mode (control bit0 = enable, bit1 = master), a data-register write while idle causes exactly 8 serial clock pulses. Then `sck_out` rests low and status bit0 (transfer done) is 1.
- R3: The divide factor is chosen by control bits [5:4] (rate) and bit6 (double speed). With bit6=0, rates 0..3 give 4, 16, 64, 128. With bit6=1, they give 2, 8, 32, 64. The done flag appears 8 × divide system cycles after the write edge.
- R4: Control bit2 = 1 sends the least significant bit first on `mosi_out`. Bit2 = 0 sends the most significant bit first.
- R5: A transfer swaps the bytes: afterwards the master's data register reads the slave's loaded byte, and the slave's reads the master's byte. The slave's status bit0 is also set.
- R6: `irq` is high when status bit0 and control bit3 (interrupt enable) are both set. Pulsing `irq_ack` clears status bit0.
- R7: A data write while a transfer is active sets status bit1 (write collision) and does not change the byte being exchanged. In slave mode, "active" means selected.
- R8: A status read that sees bit0 or bit1 set, followed by any data-register access, clears both bits.
- R9: A slave takes part only while `sel_n` is low. `miso_drive` is 0 while it is deselected, and a deselected slave gains no done flag.
- R10: Raising `sel_n` in the middle of a byte returns the slave's bit counter to zero, so the next selected transfer receives a whole byte correctly.
- R11: `sck_drive` and `mosi_drive` are 1 only in enabled master mode. A slave never drives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 control, 1 status, 2 data |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| irq | output | 1 | Transfer-done interrupt request |
| irq_ack | input | 1 | Interrupt taken; clears done flag |
| sck_in | input | 1 | Serial clock input (slave) |
| sck_out | output | 1 | Serial clock output (master) |
| sck_drive | output | 1 | Enable for the serial clock driver |
| mosi_in | input | 1 | Master-out line as seen by a slave |
| mosi_out | output | 1 | Master-out data |
| mosi_drive | output | 1 | Enable for the master-out driver |
| miso_in | input | 1 | Master-in line as seen by a master |
| miso_out | output | 1 | Slave data out |
| miso_drive | output | 1 | Enable for the slave data driver |
| sel_n | input | 1 | Active-low slave select |

## Verification
The hardest state to reach from the ports is a slave that is dropped partway through a byte while the master keeps clocking, and whose next selected transfer must still land on a byte boundary. The bench connects two instances, one as master and one as slave. It raises the slave's select after a few master bit times. It then checks that the slave released its data line and did not set a done flag. A second full exchange follows, with both received bytes checked. Write collisions are reached by writing the data register a fixed number of cycles after the first write, well inside the known transfer time.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;

   // control layout, bit 0 first: enable, master, lsb_first, irq_en, rate[1:0], dbl
   typedef struct packed {
      logic       dbl;
      logic [1:0] rate;
      logic       irq_en;
      logic       lsb_first;
      logic       master;
      logic       enable;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   // log2 of the half serial period, in system clocks
   function automatic logic [2:0] half_log(input logic dbl, input logic [1:0] rate);
      logic [2:0] v;
      case ({dbl, rate})
         3'b000:  v = 3'd1;
         3'b001:  v = 3'd3;
         3'b010:  v = 3'd5;
         3'b011:  v = 3'd6;
         3'b100:  v = 3'd0;
         3'b101:  v = 3'd2;
         3'b110:  v = 3'd4;
         default: v = 3'd5;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/spi_xcvr_sync.sv
module spi_xcvr_sync #(
   parameter int             N       = 3,
   parameter int             STAGES  = 2,
   parameter logic [N-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_xcvr_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [N-1:0] r;
      if (g == 0) begin : g_in
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stage[g-1].r;
         end
      end
   end

   assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/spi_xcvr_clkdiv.sv
module spi_xcvr_clkdiv #(
   parameter int LOG_MAX = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] log_sel,
   output logic       tick
);

   localparam int CW = (LOG_MAX > 0) ? LOG_MAX : 1;

   if (LOG_MAX < 6) begin : g_bad_log
      $error("spi_xcvr_clkdiv: LOG_MAX must cover a half period of 64");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;

   assign limit = ~({CW{1'b1}} << log_sel);
   assign tick  = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || tick)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/spi_xcvr_shifter.sv
module spi_xcvr_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         cnt_clr,
   input  logic         sample,
   input  logic         in_bit,
   input  logic         shift,
   input  logic         lsb_first,
   output logic [W-1:0] q,
   output logic         out_bit,
   output logic         byte_done
);

   localparam int CW = (W > 2) ? $clog2(W) : 1;

   logic [W-1:0]  sh_q;
   logic          cap_q;
   logic [CW-1:0] cnt_q;

   assign q         = sh_q;
   assign out_bit   = lsb_first ? sh_q[0] : sh_q[W-1];
   assign byte_done = shift && (cnt_q == CW'(W-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cap_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         if (sample) cap_q <= in_bit;
         if (load)
            sh_q <= load_val;
         else if (shift)
            sh_q <= lsb_first ? {cap_q, sh_q[W-1:1]} : {sh_q[W-2:0], cap_q};
         if (cnt_clr || byte_done) cnt_q <= '0;
         else if (shift)           cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
   import spi_xcvr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int LOG_MAX     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   input  logic              irq_ack,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_drive,
   input  logic              mosi_in,
   output logic              mosi_out,
   output logic              mosi_drive,
   input  logic              miso_in,
   output logic              miso_out,
   output logic              miso_drive,
   input  logic              sel_n
);

   if (DATA_W < CTRL_W + 1) begin : g_bad_width
      $error("spi_xcvr: DATA_W too narrow for the control register");
   end

   // register file
   logic [DATA_W-1:0] ctrl_raw;
   ctrl_t             ctrl;
   logic              done_q, wcol_q, armed_q;

   assign ctrl = ctrl_t'(ctrl_raw[CTRL_W-1:0]);

   logic m_mode, s_mode;
   assign m_mode = ctrl.enable &  ctrl.master;
   assign s_mode = ctrl.enable & ~ctrl.master;

   // synchronized slave-side pins: bit2 select, bit1 data, bit0 clock
   logic [2:0] pins_s;
   logic       sck_prev, sel_prev;

   spi_xcvr_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sel_n, mosi_in, sck_in}),
      .q     (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev <= 1'b0;
         sel_prev <= 1'b1;
      end else begin
         sck_prev <= pins_s[0];
         sel_prev <= pins_s[2];
      end
   end

   logic sck_rise, sck_fall, sel_rise, sel_active;
   assign sck_rise   =  pins_s[0] & ~sck_prev;
   assign sck_fall   = ~pins_s[0] &  sck_prev;
   assign sel_rise   =  pins_s[2] & ~sel_prev;
   assign sel_active =  s_mode & ~pins_s[2];

   // bus decode
   logic data_wr, data_rd, stat_rd, ctrl_wr;
   assign data_wr = reg_wr && (reg_addr == ADDR_DATA);
   assign data_rd = reg_rd && (reg_addr == ADDR_DATA);
   assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);
   assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

   // master sequencing
   logic busy_q, sclk_q, tick;
   logic xfer_busy, collide, start, load;
   logic m_sample, m_shift, sample, shift, in_bit;
   logic [DATA_W-1:0] sh_val;
   logic out_bit, byte_done;

   assign xfer_busy = m_mode ? busy_q : sel_active;
   assign collide   = data_wr &&  xfer_busy;
   assign load      = data_wr && !xfer_busy;
   assign start     = load && m_mode;

   spi_xcvr_clkdiv #(.LOG_MAX(LOG_MAX)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy_q),
      .log_sel (half_log(ctrl.dbl, ctrl.rate)),
      .tick    (tick)
   );

   assign m_sample = tick && !sclk_q;
   assign m_shift  = tick &&  sclk_q;
   assign sample   = m_mode ? m_sample : (sel_active && sck_rise);
   assign shift    = m_mode ? m_shift  : (sel_active && sck_fall);
   assign in_bit   = m_mode ? miso_in  : pins_s[1];

   spi_xcvr_shifter #(.W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_val  (reg_wdata),
      .cnt_clr   (start || (s_mode && sel_rise)),
      .sample    (sample),
      .in_bit    (in_bit),
      .shift     (shift),
      .lsb_first (ctrl.lsb_first),
      .q         (sh_val),
      .out_bit   (out_bit),
      .byte_done (byte_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
      end else if (!m_mode) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         if (byte_done)     busy_q <= 1'b0;
         if (m_sample)      sclk_q <= 1'b1;
         else if (m_shift)  sclk_q <= 1'b0;
      end
   end

   // control and flags
   logic flag_clr;
   assign flag_clr = (data_wr || data_rd) && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_raw <= '0;
         done_q   <= 1'b0;
         wcol_q   <= 1'b0;
         armed_q  <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_raw <= reg_wdata;

         if (byte_done)                done_q <= 1'b1;
         else if (flag_clr || irq_ack) done_q <= 1'b0;

         if (collide)       wcol_q <= 1'b1;
         else if (flag_clr) wcol_q <= 1'b0;

         if (data_wr || data_rd)           armed_q <= 1'b0;
         else if (stat_rd && (done_q || wcol_q)) armed_q <= 1'b1;
      end
   end

   always_comb begin
      case (reg_addr)
         ADDR_CTRL: reg_rdata = ctrl_raw;
         ADDR_STAT: reg_rdata = DATA_W'({wcol_q, done_q});
         ADDR_DATA: reg_rdata = sh_val;
         default:   reg_rdata = '0;
      endcase
   end

   // pins
   assign irq        = done_q && ctrl.irq_en;
   assign sck_out    = sclk_q;
   assign sck_drive  = m_mode;
   assign mosi_out   = m_mode && out_bit;
   assign mosi_drive = m_mode;
   assign miso_out   = sel_active && out_bit;
   assign miso_drive = sel_active;

endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic busy_q,
   input logic sck_out,
   input logic m_mode,
   input logic byte_done,
   input logic data_wr,
   input logic wcol_q,
   input logic irq_ack,
   input logic irq,
   input logic sel_n,
   input logic miso_drive
);

   // R2: the serial clock rests low whenever no master transfer runs
   a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sck_out);

   // R2: the eighth bit ends the master transfer
   a_r2_stop_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (m_mode && byte_done) |=> !busy_q);

   // R7: a data write during a transfer flags a collision
   a_r7_wcol_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && busy_q) |=> wcol_q);

   // R7: such a write does not abort the exchange
   a_r7_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (m_mode && data_wr && busy_q && !byte_done) |=> busy_q);

   // R6: an acknowledge drops the request unless a byte completes at once
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !byte_done) |=> !irq);

   // R9: a slave held deselected never drives its data line
   if (SYNC_STAGES <= 3) begin : g_sel_chk
      a_r9_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_n && $past(sel_n) && $past(sel_n, 2) && $past(sel_n, 3)) |-> !miso_drive);
   end

endmodule

bind spi_xcvr spi_xcvr_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_q     (busy_q),
   .sck_out    (sck_out),
   .m_mode     (m_mode),
   .byte_done  (byte_done),
   .data_wr    (data_wr),
   .wcol_q     (wcol_q),
   .irq_ack    (irq_ack),
   .irq        (irq),
   .sel_n      (sel_n),
   .miso_drive (miso_drive)
);

// File: tb/spi_xcvr_tb_top.sv
module spi_xcvr_tb_top;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n;
   logic       wr [2];
   logic       rd [2];
   logic [1:0] addr [2];
   logic [7:0] wdata [2];
   logic [7:0] rdata [2];
   logic       irq [2];
   logic       ack [2];
   logic       loop_mode, sel_n;

   logic m_sck, m_sck_drv, m_mosi, m_mosi_drv, m_miso, m_miso_drv;
   logic s_sck, s_sck_drv, s_mosi, s_mosi_drv, s_miso, s_miso_drv;
   logic m_miso_in;

   assign m_miso_in = loop_mode ? m_mosi : (s_miso_drv ? s_miso : 1'b1);

   spi_xcvr dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr[0]), .reg_rd(rd[0]), .reg_addr(addr[0]),
      .reg_wdata(wdata[0]), .reg_rdata(rdata[0]), .irq(irq[0]), .irq_ack(ack[0]),
      .sck_in(1'b0), .sck_out(m_sck), .sck_drive(m_sck_drv),
      .mosi_in(1'b0), .mosi_out(m_mosi), .mosi_drive(m_mosi_drv),
      .miso_in(m_miso_in), .miso_out(m_miso), .miso_drive(m_miso_drv), .sel_n(1'b1)
   );

   spi_xcvr slave_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr[1]), .reg_rd(rd[1]), .reg_addr(addr[1]),
      .reg_wdata(wdata[1]), .reg_rdata(rdata[1]), .irq(irq[1]), .irq_ack(ack[1]),
      .sck_in(m_sck), .sck_out(s_sck), .sck_drive(s_sck_drv),
      .mosi_in(m_mosi), .mosi_out(s_mosi), .mosi_drive(s_mosi_drv),
      .miso_in(1'b0), .miso_out(s_miso), .miso_drive(s_miso_drv), .sel_n(sel_n)
   );

   // serial stream seen on the master-out line, first bit ends up on the left
   logic [7:0] cap = 8'h00;
   always @(posedge m_sck) cap <= {cap[6:0], m_mosi};

   int checks = 0;
   int fails  = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input int i, input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr[i] = 1'b1; addr[i] = a; wdata[i] = d;
      @(posedge clk);
      @(negedge clk);
      wr[i] = 1'b0;
   endtask

   task automatic bus_rd(input int i, input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      rd[i] = 1'b1; addr[i] = a;
      #1 v = rdata[i];
      @(posedge clk);
      @(negedge clk);
      rd[i] = 1'b0;
   endtask

   task automatic wait_irq(input int i, output int n);
      n = 0;
      while (n < 5000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (irq[i]) break;
      end
   endtask

   function automatic int div_of(input logic dbl, input logic [1:0] sel);
      if (dbl) return (sel == 0) ? 2 : (sel == 1) ? 8 : (sel == 2) ? 32 : 64;
      else     return (sel == 0) ? 4 : (sel == 1) ? 16 : (sel == 2) ? 64 : 128;
   endfunction

   function automatic logic [7:0] rev8(input logic [7:0] v);
      for (int k = 0; k < 8; k++) rev8[k] = v[7-k];
   endfunction

   // fields: dbl, rate, lsb_first, loopback, master byte, slave byte
   localparam int NV = 8;
   localparam logic [20:0] VEC [NV] = '{
      {1'b0, 2'd0, 1'b0, 1'b1, 8'hA5, 8'h00},
      {1'b1, 2'd0, 1'b1, 1'b1, 8'h1E, 8'h00},
      {1'b1, 2'd1, 1'b0, 1'b0, 8'h3C, 8'h96},
      {1'b0, 2'd1, 1'b1, 1'b0, 8'h81, 8'h7E},
      {1'b1, 2'd2, 1'b0, 1'b0, 8'hF0, 8'h0F},
      {1'b0, 2'd2, 1'b1, 1'b0, 8'h01, 8'h80},
      {1'b1, 2'd3, 1'b0, 1'b0, 8'h6B, 8'hD2},
      {1'b0, 2'd3, 1'b1, 1'b0, 8'hFF, 8'h00}
   };

   localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      int n;
      for (int i = 0; i < 2; i++) begin
         wr[i] = 0; rd[i] = 0; addr[i] = 0; wdata[i] = 0; ack[i] = 0;
      end
      loop_mode = 1'b1;
      sel_n     = 1'b1;
      rst_n     = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #1 check("R1 ctrl", rdata[0], 8'h00);
      check("R1 irq", irq[0], 1'b0);
      check("R1 drives", {m_sck_drv, m_mosi_drv, m_miso_drv}, 3'b000);
      bus_rd(0, A_STAT, v); check("R1 status", v, 8'h00);

      // table of exchanges
      for (int t = 0; t < NV; t++) begin
         logic       dbl, lsb, lp;
         logic [1:0] sel;
         logic [7:0] mb, sb;
         {dbl, sel, lsb, lp, mb, sb} = VEC[t];
         loop_mode = lp;
         bus_wr(0, A_CTRL, {1'b0, dbl, sel, 1'b1, lsb, 1'b1, 1'b1});
         check("R11 master drives", {m_sck_drv, m_mosi_drv}, 2'b11);
         if (!lp) begin
            bus_wr(1, A_CTRL, {4'b0000, 1'b0, lsb, 1'b0, 1'b1});
            bus_wr(1, A_DATA, sb);
            sel_n = 1'b0;
            repeat (4) @(negedge clk);
            check("R11 slave no drive", {s_sck_drv, s_mosi_drv}, 2'b00);
         end
         bus_wr(0, A_DATA, mb);
         wait_irq(0, n);
         check("R3 cycles to done", n, 8 * div_of(dbl, sel));
         check("R2 sck parked low", m_sck, 1'b0);
         check("R4 bit order on line", cap, lsb ? rev8(mb) : mb);
         bus_rd(0, A_STAT, v); check("R2 done flag", v, 8'h01);
         bus_rd(0, A_DATA, v); check("R5 master received", v, lp ? mb : sb);
         bus_rd(0, A_STAT, v); check("R8 flags cleared", v, 8'h00);
         check("R6 irq dropped", irq[0], 1'b0);
         if (!lp) begin
            repeat (8) @(negedge clk);
            bus_rd(1, A_STAT, v); check("R5 slave done", v, 8'h01);
            bus_rd(1, A_DATA, v); check("R5 slave received", v, mb);
            sel_n = 1'b1;
            repeat (4) @(negedge clk);
         end
      end

      // R7 collision during a master transfer, R8 clear sequence
      loop_mode = 1'b1;
      bus_wr(0, A_CTRL, {1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1});
      bus_wr(0, A_DATA, 8'h3C);
      repeat (20) @(negedge clk);
      bus_wr(0, A_DATA, 8'hFF);
      bus_rd(0, A_STAT, v); check("R7 wcol set", v, 8'h02);
      wait_irq(0, n);
      bus_rd(0, A_DATA, v); check("R7 byte unchanged", v, 8'h3C);
      bus_rd(0, A_STAT, v); check("R8 both cleared", v, 8'h00);

      // R6 acknowledge clears done
      bus_wr(0, A_CTRL, {1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1});
      bus_wr(0, A_DATA, 8'h55);
      wait_irq(0, n);
      check("R6 irq raised", irq[0], 1'b1);
      @(negedge clk); ack[0] = 1'b1;
      @(negedge clk); ack[0] = 1'b0;
      check("R6 irq after ack", irq[0], 1'b0);
      bus_rd(0, A_STAT, v); check("R6 done after ack", v, 8'h00);

      // R6 interrupt disabled
      bus_wr(0, A_CTRL, {1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1});
      bus_wr(0, A_DATA, 8'h77);
      repeat (40) @(negedge clk);
      check("R6 irq masked", irq[0], 1'b0);
      bus_rd(0, A_STAT, v); check("R6 done while masked", v, 8'h01);
      bus_rd(0, A_DATA, v); check("R5 loopback byte", v, 8'h77);

      // R7 slave write while selected
      bus_wr(1, A_CTRL, 8'h01);
      bus_wr(1, A_DATA, 8'h11);
      sel_n = 1'b0;
      repeat (4) @(negedge clk);
      bus_wr(1, A_DATA, 8'h22);
      bus_rd(1, A_STAT, v); check("R7 slave wcol", v, 8'h02);
      bus_rd(1, A_DATA, v); check("R7 slave byte kept", v, 8'h11);
      sel_n = 1'b1;
      repeat (4) @(negedge clk);

      // R9 and R10 deselect in mid-byte
      loop_mode = 1'b0;
      bus_wr(0, A_CTRL, {1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1});
      bus_wr(1, A_DATA, 8'h0F);
      sel_n = 1'b0;
      repeat (4) @(negedge clk);
      bus_wr(0, A_DATA, 8'hA5);
      repeat (96) @(negedge clk);
      sel_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R9 miso released", s_miso_drv, 1'b0);
      wait_irq(0, n);
      bus_rd(0, A_STAT, v);
      bus_rd(0, A_DATA, v);
      repeat (8) @(negedge clk);
      bus_rd(1, A_STAT, v); check("R9 no slave done", v, 8'h00);
      bus_wr(1, A_DATA, 8'h81);
      sel_n = 1'b0;
      repeat (4) @(negedge clk);
      bus_wr(0, A_DATA, 8'h5A);
      wait_irq(0, n);
      repeat (8) @(negedge clk);
      bus_rd(1, A_STAT, v); check("R10 slave done once", v, 8'h01);
      bus_rd(1, A_DATA, v); check("R10 slave full byte", v, 8'h5A);
      bus_rd(0, A_STAT, v);
      bus_rd(0, A_DATA, v); check("R10 master full byte", v, 8'h81);
      sel_n = 1'b1;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule